// File: doc/BRIEF.md
# Flash Status Register Protection Logic

This block holds the status register of a serial NOR flash model and decides, one decoded command at a time, whether a write-type request may go ahead. It keeps a volatile write-enable latch, a three-bit protect code that guards a region at the top of the array, and a one-time-programmable lock bit that freezes the protect code for good. The command decoder raises exactly one strobe per command, together with the target address or the new status byte. In the same cycle the block answers with a grant or a refusal. The resulting register update is visible on the status output after the next rising clock edge.

The model has two resets. `por_n` stands for a power cycle with factory-fresh storage and clears every bit. `rst_n` is an ordinary reset that clears only the volatile latch, so the protect code and the lock bit carry across it as non-volatile storage would. The memory array, the busy timing and the serial shifting sit outside the block. The busy flag is only passed through into the status byte.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte is {lock, 0, 0, protect[2:0], latch, busy}: bit 7 is the lock, bits 6:5 read 0, bits 4:2 hold the protect code, bit 1 is the write-enable latch and bit 0 copies `busy`.
- R2: A write-enable strobe is always granted and sets the latch. A write-disable strobe is always granted and clears it.
- R3: While the latch is 0, every status-write, page-program, sector-erase, block-erase and chip-erase request is refused.
- R4: Protect code n (1 to 7) guards every address whose top six bits are at least 64 - 2^(n-1). Code 7 therefore guards the whole array and code 0 guards nothing. Program, sector erase and block erase aimed at a guarded address are refused.
- R5: Chip erase is refused whenever the protect code is nonzero.
- R6: While the lock bit is 1, status-write requests are refused and the protect code cannot change.
- R7: Once set, the lock bit stays 1 until `por_n` is asserted.
- R8: A granted program, erase or status-write clears the latch. A refused request leaves the latch as it was.
- R9: `rst_n` clears the latch and keeps the protect code and the lock bit. `por_n` clears all three.
- R10: The protect code and the lock bit change only through a granted status write. That write loads them from data bits 4:2 and bit 7.
- R11: When a strobe is present, exactly one of `grant` and `refuse` is high. When no strobe is present, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Warm reset, active low, clears only the latch |
| busy | input | 1 | Busy flag reflected in status bit 0 |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| cmd_pp | input | 1 | Page-program command strobe |
| cmd_se | input | 1 | Sector-erase command strobe |
| cmd_be | input | 1 | Block-erase command strobe |
| cmd_ce | input | 1 | Chip-erase command strobe |
| addr | input | ADDR_W | Target byte address |
| sr_data | input | 8 | New status byte for a status write |
| grant | output | 1 | Request allowed this cycle |
| refuse | output | 1 | Request rejected this cycle |
| status | output | 8 | Status byte for readback |

## Verification
Two effects can fall on one edge. A single status write can set the lock bit and load a new protect code at the same time, because the lock only takes effect from the following cycle. The bench sends the byte 0x94 with the latch set. It expects both fields to commit together, then expects the next status write to be refused with the latch left standing. A second case is a refused request that arrives with the latch set. The bench judges it by reading the latch back, checking that it stays 1 across the edge on which an accepted request would have cleared it.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        sr_data,
  output logic              grant,
  output logic              refuse,
  output logic [7:0]        status
);
  localparam int ZONE_W = 6;
  localparam logic [ZONE_W:0] ZONES = 7'(1 << ZONE_W);

  logic       wr_latch;
  logic [2:0] prot_code;
  logic       sr_lock;
  logic [ZONE_W:0] zone_floor;

  wire [ZONE_W-1:0] zone = addr[ADDR_W-1 -: ZONE_W];
  wire array_op = cmd_pp | cmd_se | cmd_be;
  wire write_op = array_op | cmd_wrsr | cmd_ce;

  always_comb begin
    if (prot_code == 3'd0) zone_floor = ZONES;
    else                   zone_floor = ZONES - (7'd1 << (prot_code - 3'd1));
  end

  wire in_zone   = {1'b0, zone} >= zone_floor;
  wire ok_wrsr   = cmd_wrsr & wr_latch & ~sr_lock;
  wire ok_array  = array_op & wr_latch & ~in_zone;
  wire ok_chip   = cmd_ce & wr_latch & (prot_code == 3'd0);
  wire ok_write  = ok_wrsr | ok_array | ok_chip;

  assign grant  = cmd_wren | cmd_wrdi | ok_write;
  assign refuse = write_op & ~ok_write;
  assign status = {sr_lock, 2'b00, prot_code, wr_latch, busy};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prot_code <= 3'd0;
      sr_lock   <= 1'b0;
    end else if (rst_n && ok_wrsr) begin
      prot_code <= sr_data[4:2];
      sr_lock   <= sr_data[7];
    end
  end

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n)        wr_latch <= 1'b0;
    else if (cmd_wren)           wr_latch <= 1'b1;
    else if (cmd_wrdi | ok_write) wr_latch <= 1'b0;
  end
endmodule

module flash_status_guard_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_wrsr,
  input logic              cmd_pp,
  input logic              cmd_se,
  input logic              cmd_be,
  input logic              cmd_ce,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        sr_data,
  input logic              grant,
  input logic              refuse,
  input logic [7:0]        status
);
  wire wr_req = cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;
  wire any_req = wr_req | cmd_wren | cmd_wrdi;

  assert_layout_R1: assert property (@(posedge clk) disable iff (!por_n)
    status[6:5] == 2'b00 && status[0] == busy);

  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    cmd_wren |=> status[1]);

  assert_latch_gate_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_req && !status[1]) |-> (refuse && !grant));

  assert_chip_veto_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (cmd_ce && status[4:2] != 3'd0) |-> refuse);

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!por_n)
    status[7] |=> $stable(status[4:2]));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    status[7] |=> status[7]);

  assert_grant_clears_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (grant && wr_req) |=> !status[1]);

  assert_refuse_keeps_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    refuse |=> $stable(status[1]));

  assert_nv_path_R10: assert property (@(posedge clk) disable iff (!por_n)
    !(cmd_wrsr && grant && rst_n) |=> $stable(status[7:2]));

  assert_one_answer_R11: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({grant, refuse}) && (any_req == (grant | refuse)));
endmodule

bind flash_status_guard flash_status_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_status_guard_test.sv
module flash_status_guard_test;
  localparam int AW = 18;
  localparam int K_WREN = 0, K_WRDI = 1, K_WRSR = 2, K_PP = 3, K_SE = 4, K_BE = 5, K_CE = 6;

  logic clk = 0, por_n = 0, rst_n = 0, busy = 0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0, cmd_ce = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] sr_data = '0;
  logic grant, refuse;
  logic [7:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_status_guard #(.ADDR_W(AW)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                    input bit exp_grant, input string req);
    @(negedge clk);
    addr = a; sr_data = d;
    cmd_wren = (kind == K_WREN); cmd_wrdi = (kind == K_WRDI); cmd_wrsr = (kind == K_WRSR);
    cmd_pp = (kind == K_PP); cmd_se = (kind == K_SE); cmd_be = (kind == K_BE); cmd_ce = (kind == K_CE);
    #2;
    check(grant == exp_grant && refuse == !exp_grant, req, {grant, refuse}, {exp_grant, !exp_grant});
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce} = '0;
  endtask

  task automatic expect_status(input logic [7:0] exp, input string req);
    #1;
    check(status == exp, req, status, exp);
  endtask

  task automatic t_reset;
    expect_status(8'h00, "R9 por clears all");
    #1;
    check(grant == 0 && refuse == 0, "R11 idle silent", {grant, refuse}, 0);
    busy = 1; expect_status(8'h01, "R1 busy bit");
    busy = 0;
  endtask

  task automatic t_latch;
    op(K_PP, 18'h00100, 8'h00, 0, "R3 program without latch");
    expect_status(8'h00, "R3 status unchanged");
    op(K_CE, '0, 8'h00, 0, "R3 chip erase without latch");
    op(K_WREN, '0, 8'h00, 1, "R2 write enable");
    expect_status(8'h02, "R2 latch set");
    op(K_WRDI, '0, 8'h00, 1, "R2 write disable");
    expect_status(8'h00, "R2 latch cleared");
  endtask

  task automatic t_protect3;
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_WRSR, '0, 8'h0C, 1, "R10 status write");
    expect_status(8'h0C, "R10 code 3 loaded, R8 latch cleared");
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_PP, 18'h3C000, 8'h00, 0, "R4 program in guarded zone");
    expect_status(8'h0E, "R8 refused keeps latch");
    op(K_CE, '0, 8'h00, 0, "R5 chip erase vetoed");
    expect_status(8'h0E, "R5 latch kept");
    op(K_PP, 18'h3BFFF, 8'h00, 1, "R4 program just below zone");
    expect_status(8'h0C, "R8 granted clears latch");
  endtask

  task automatic t_codes;
    for (int n = 1; n <= 7; n++) begin
      int floor_zone = 64 - (1 << (n - 1));
      logic [AW-1:0] edge_a = AW'(floor_zone) << (AW - 6);
      op(K_WREN, '0, 8'h00, 1, "R2 enable");
      op(K_WRSR, '0, 8'(n << 2), 1, "R10 load code");
      op(K_WREN, '0, 8'h00, 1, "R2 enable");
      op(K_SE, edge_a, 8'h00, 0, "R4 sector erase at zone floor");
      op(K_BE, {AW{1'b1}}, 8'h00, 0, "R4 block erase at top");
      if (floor_zone > 0) op(K_SE, edge_a - 1, 8'h00, 1, "R4 sector erase below floor");
      else op(K_WRDI, '0, 8'h00, 1, "R2 disable");
      expect_status(8'(n << 2), "R4 code retained");
    end
  endtask

  task automatic t_chip_clear;
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_WRSR, '0, 8'h00, 1, "R10 clear code");
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_PP, {AW{1'b1}}, 8'h00, 1, "R4 code 0 guards nothing");
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_CE, '0, 8'h00, 1, "R5 chip erase with code 0");
    expect_status(8'h00, "R8 latch cleared");
  endtask

  task automatic t_warm_reset;
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_WRSR, '0, 8'h14, 1, "R10 load code 5");
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    expect_status(8'h16, "R9 before warm reset");
    rst_n = 0; @(negedge clk); rst_n = 1;
    expect_status(8'h14, "R9 warm reset keeps code");
  endtask

  task automatic t_lock;
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_WRSR, '0, 8'h94, 1, "R6 lock and code together");
    expect_status(8'h94, "R7 lock and code committed");
    op(K_WREN, '0, 8'h00, 1, "R2 enable");
    op(K_WRSR, '0, 8'h00, 0, "R6 status write locked");
    expect_status(8'h96, "R6 code frozen, R7 lock held");
    rst_n = 0; @(negedge clk); rst_n = 1;
    expect_status(8'h94, "R7 lock survives warm reset");
    por_n = 0; @(negedge clk); por_n = 1;
    expect_status(8'h00, "R9 por clears lock");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    t_reset();
    t_latch();
    t_protect3();
    t_codes();
    t_chip_clear();
    t_warm_reset();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule